// File: doc/BRIEF.md
# Suspend Entry and Clock Release Sequencer

This block controls how a multi-group clock generator goes into a suspend state and comes back out of it. It watches an active-low suspend request and filters it. When the request holds, it stops the output groups one at a time in a fixed order. Once every group is stopped, it powers down the PLL and the crystal oscillator. When the request is withdrawn, the PLL and oscillator start again first. No group restarts until the PLL reports lock. The groups then return in a different order from the one they stopped in. One buffered 66 MHz output comes back together with the CPU clocks, so that a chipset DLL has a feedback path early. The other buffered outputs follow after a delay counted in reference ticks.

Each group has a clock input, which carries that group's clock level as seen in the sequencer clock domain. Each group also has an enable output. An enable only changes on the edge of its own group's clock that is safe for that group, so a gated output never glitches. Every single-ended group switches on a falling edge, which makes it stop low. The CPU pairs switch on a rising edge, so the true leg is held high. While the CPU pairs are stopped, the complement leg is left undriven. The sequencer moves from one step to the next only after every enable has settled at its new value.

Top module: `clk_suspend_seq`

## Requirements
- R1: The suspend request takes effect only after `pd_n` has been sampled low on two consecutive `clk` edges. It is withdrawn only after `pd_n` has been sampled high on two consecutive edges. A one-cycle pulse of `pd_n` changes nothing.
- R2: Groups stop in this order. First the PCI group (bit 4). Then both buffered 66 MHz groups (bits 2 and 3). Then the CPU group and the PLL-driven 66 MHz group (bits 0 and 1). Then the 48 MHz group (bit 5). Then the reference group (bit 6). Each stage starts strictly after the one before it has settled. `pll_pd` and `osc_pd` go high only after every enable is 0. The enable bit map is bit 0 CPU, bit 1 PLL-driven 66 MHz, bit 2 early buffered 66 MHz, bit 3 other buffered 66 MHz, bit 4 PCI, bit 5 48 MHz, bit 6 reference.
- R3: An enable bit changes only in the `clk` cycle after its group clock level was sampled going from 1 to 0. The CPU bit (bit 0) is the exception: it changes after the level was sampled going from 0 to 1.
- R4: While the CPU enable is 0, `cpu_true_hold` is 1 and `cpu_comp_oe` is 0. Otherwise `cpu_true_hold` is 0 and `cpu_comp_oe` is 1.
- R5: On exit, `pll_pd` and `osc_pd` return to 0 first. No enable rises before `pll_lock` has been seen high.
- R6: Once lock is seen, bits 0, 1 and 2 are released in one step. Each rises at its own next safe edge, and all three rise before any other group.
- R7: After the step of R6 settles, the sequencer waits `EXIT_TICKS` reference ticks (default 1432, about 100 us at 14.318 MHz). It then releases bit 3. After bit 3, it releases bit 4. After bit 4, it releases bits 5 and 6.
- R8: A suspend request accepted during exit aborts the exit. No group still stopped is released. Entry restarts from the current enables in the order of R2.
- R9: While and after reset, all seven enables are 1 and `pll_pd` and `osc_pd` are 0.
- R10: At the default parameters, every group is running again well within 3 ms after `pd_n` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock (CPU clock domain) |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Active-low suspend request |
| pll_lock | input | 1 | PLL lock indication |
| ref_tick | input | 1 | One-cycle pulse per reference period |
| grp_clk | input | 7 | Per-group clock levels, bit map as in R2 |
| grp_en | output | 7 | Per-group enables, bit map as in R2 |
| cpu_true_hold | output | 1 | Drive the CPU true legs high |
| cpu_comp_oe | output | 1 | Drive enable for the CPU complement legs |
| pll_pd | output | 1 | PLL power-down |
| osc_pd | output | 1 | Oscillator power-down |

## Verification
The request filter acts on the second of two equal samples of `pd_n`. An enable moves in the cycle after its group's level edge was sampled. Each step then waits for all enables to settle. The exit delay is a further `EXIT_TICKS` reference ticks, and the time to lock depends on the lock model.

Because the exact landing cycle of each step depends on the group clock phases, the final values are not checked at a fixed cycle. They are sampled on the falling clock edge at the end of settle windows that are longer than any step can take. The bench records the cycle of every enable change and checks those cycles against one another. This covers the stop and release order, the lock gate and the exit delay window. Edge alignment is checked in every cycle against the group clock levels the bench itself drove in the two previous cycles.

// File: rtl/clk_seq_pkg.sv
package clk_seq_pkg;

    localparam int NGRP = 7;

    localparam int G_CPU  = 0;
    localparam int G_P66  = 1;
    localparam int G_B66E = 2;
    localparam int G_B66  = 3;
    localparam int G_PCI  = 4;
    localparam int G_M48  = 5;
    localparam int G_REF  = 6;

    typedef logic [NGRP-1:0] grp_vec_t;

    localparam grp_vec_t M_CPU  = grp_vec_t'(1) << G_CPU;
    localparam grp_vec_t M_P66  = grp_vec_t'(1) << G_P66;
    localparam grp_vec_t M_B66E = grp_vec_t'(1) << G_B66E;
    localparam grp_vec_t M_B66  = grp_vec_t'(1) << G_B66;
    localparam grp_vec_t M_PCI  = grp_vec_t'(1) << G_PCI;
    localparam grp_vec_t M_M48  = grp_vec_t'(1) << G_M48;
    localparam grp_vec_t M_REF  = grp_vec_t'(1) << G_REF;

    localparam grp_vec_t M_NONE   = '0;
    localparam grp_vec_t M_ALL    = '1;
    localparam grp_vec_t M_EARLY  = M_CPU | M_P66 | M_B66E;
    // groups whose enable moves on a rising level edge (stop high)
    localparam grp_vec_t RISE_MASK = M_CPU;

    typedef enum logic [3:0] {
        S_RUN,
        S_E_PCI,
        S_E_BUF,
        S_E_CPU,
        S_E_M48,
        S_E_REF,
        S_OFF,
        S_X_LOCK,
        S_X_EARLY,
        S_X_WAIT,
        S_X_BUF,
        S_X_PCI,
        S_X_LAST
    } seq_state_e;

    typedef struct packed {
        seq_state_e nxt;
        grp_vec_t   clr;
        grp_vec_t   set;
    } step_t;

    function automatic logic is_exit(seq_state_e s);
        return (s == S_X_LOCK) || (s == S_X_EARLY) || (s == S_X_WAIT) ||
               (s == S_X_BUF)  || (s == S_X_PCI)   || (s == S_X_LAST);
    endfunction

    function automatic logic waits_settle(seq_state_e s);
        return (s == S_E_PCI) || (s == S_E_BUF) || (s == S_E_CPU) ||
               (s == S_E_M48) || (s == S_E_REF) || (s == S_X_EARLY) ||
               (s == S_X_BUF) || (s == S_X_PCI) || (s == S_X_LAST);
    endfunction

    // step taken once all enables have reached the wanted value
    function automatic step_t advance(seq_state_e s);
        step_t r;
        r = '{nxt: s, clr: M_NONE, set: M_NONE};
        case (s)
            S_E_PCI:   r = '{nxt: S_E_BUF,  clr: M_B66 | M_B66E, set: M_NONE};
            S_E_BUF:   r = '{nxt: S_E_CPU,  clr: M_CPU | M_P66,  set: M_NONE};
            S_E_CPU:   r = '{nxt: S_E_M48,  clr: M_M48,          set: M_NONE};
            S_E_M48:   r = '{nxt: S_E_REF,  clr: M_REF,          set: M_NONE};
            S_E_REF:   r = '{nxt: S_OFF,    clr: M_NONE,         set: M_NONE};
            S_X_EARLY: r = '{nxt: S_X_WAIT, clr: M_NONE,         set: M_NONE};
            S_X_BUF:   r = '{nxt: S_X_PCI,  clr: M_NONE,         set: M_PCI};
            S_X_PCI:   r = '{nxt: S_X_LAST, clr: M_NONE,         set: M_M48 | M_REF};
            S_X_LAST:  r = '{nxt: S_RUN,    clr: M_NONE,         set: M_NONE};
            default:   r = '{nxt: s,        clr: M_NONE,         set: M_NONE};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pd_req_filter.sv
module pd_req_filter (
    input  logic clk,
    input  logic rst,
    input  logic pd_n,
    output logic req
);

    logic s0;

    always_ff @(posedge clk) begin
        if (rst) begin
            s0  <= 1'b1;
            req <= 1'b0;
        end else begin
            s0 <= pd_n;
            if (!pd_n && !s0) begin
                req <= 1'b1;
            end else if (pd_n && s0) begin
                req <= 1'b0;
            end
        end
    end

    // R1: request asserts only after two low samples in a row
    p_filter_on_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> (!$past(pd_n) && !$past(s0)));

    // R1: request clears only after two high samples in a row
    p_filter_off_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(req) |-> ($past(pd_n) && $past(s0)));

endmodule

// File: rtl/grp_clk_gate.sv
module grp_clk_gate #(
    parameter bit RISE = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic want,
    output logic en
);

    logic prev;
    logic safe_edge;

    always_comb begin
        if (RISE) begin
            safe_edge = !prev && lvl;
        end else begin
            safe_edge = prev && !lvl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b0;
            en   <= 1'b1;
        end else begin
            prev <= lvl;
            if (safe_edge) begin
                en <= want;
            end
        end
    end

    // R3: the enable only moves right after the group's safe level edge
    p_edge_only_r3: assert property (@(posedge clk) disable iff (rst)
        (en != $past(en)) |-> (($past(prev) == !RISE) && ($past(lvl) == RISE)));

endmodule

// File: rtl/suspend_fsm.sv
module suspend_fsm
    import clk_seq_pkg::*;
#(
    parameter int unsigned EXIT_TICKS = 1432
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req,
    input  logic     lock,
    input  logic     ref_tick,
    input  grp_vec_t en,
    output grp_vec_t want,
    output logic     pwr_down
);

    localparam int CW = (EXIT_TICKS > 1) ? $clog2(EXIT_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(EXIT_TICKS - 1);

    seq_state_e    st, st_n;
    grp_vec_t      want_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          settled;
    step_t         adv;

    assign settled = (en == want);
    assign adv     = advance(st);

    always_comb begin
        st_n   = st;
        want_n = want;
        cnt_n  = cnt;
        if (req && ((st == S_RUN) || is_exit(st))) begin
            st_n   = S_E_PCI;
            want_n = want & ~M_PCI;
        end else if (waits_settle(st)) begin
            if (settled) begin
                st_n   = adv.nxt;
                want_n = (want & ~adv.clr) | adv.set;
                cnt_n  = '0;
            end
        end else begin
            case (st)
                S_OFF: begin
                    if (!req) begin
                        st_n = S_X_LOCK;
                    end
                end
                S_X_LOCK: begin
                    if (lock) begin
                        st_n   = S_X_EARLY;
                        want_n = want | M_EARLY;
                    end
                end
                S_X_WAIT: begin
                    if (ref_tick) begin
                        if (cnt == LAST) begin
                            st_n   = S_X_BUF;
                            want_n = want | M_B66;
                        end else begin
                            cnt_n = cnt + 1'b1;
                        end
                    end
                end
                default: begin
                    st_n = st;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= S_RUN;
            want <= M_ALL;
            cnt  <= '0;
        end else begin
            st   <= st_n;
            want <= want_n;
            cnt  <= cnt_n;
        end
    end

    assign pwr_down = (st == S_OFF);

    // R2: PLL and oscillator go down only with every group stopped
    p_pll_off_r2: assert property (@(posedge clk) disable iff (rst)
        pwr_down |-> (en == M_NONE));

    // R5: no group is asked to run again unless lock was seen
    p_lock_gate_r5: assert property (@(posedge clk) disable iff (rst)
        ((want & ~$past(want)) != M_NONE) |-> $past(lock));

    // R7: leaving the wait needs the full tick count
    p_exit_delay_r7: assert property (@(posedge clk) disable iff (rst)
        ((st == S_X_BUF) && ($past(st) == S_X_WAIT)) |->
            ($past(cnt) == LAST && $past(ref_tick)));

    // R8: an accepted request never lets a group be released
    p_abort_r8: assert property (@(posedge clk) disable iff (rst)
        $past(req) |-> ((want & ~$past(want)) == M_NONE));

endmodule

// File: rtl/clk_suspend_seq.sv
module clk_suspend_seq
    import clk_seq_pkg::*;
#(
    parameter int unsigned EXIT_TICKS = 1432
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pd_n,
    input  logic       pll_lock,
    input  logic       ref_tick,
    input  logic [6:0] grp_clk,
    output logic [6:0] grp_en,
    output logic       cpu_true_hold,
    output logic       cpu_comp_oe,
    output logic       pll_pd,
    output logic       osc_pd
);

    logic     req;
    logic     pwr_down;
    grp_vec_t want;
    grp_vec_t en;

    pd_req_filter u_filter (
        .clk  (clk),
        .rst  (rst),
        .pd_n (pd_n),
        .req  (req)
    );

    suspend_fsm #(
        .EXIT_TICKS (EXIT_TICKS)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .lock     (pll_lock),
        .ref_tick (ref_tick),
        .en       (en),
        .want     (want),
        .pwr_down (pwr_down)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_gate
        grp_clk_gate #(
            .RISE (RISE_MASK[g])
        ) u_gate (
            .clk  (clk),
            .rst  (rst),
            .lvl  (grp_clk[g]),
            .want (want[g]),
            .en   (en[g])
        );
    end

    assign grp_en        = en;
    assign cpu_true_hold = !en[G_CPU];
    assign cpu_comp_oe   = en[G_CPU];
    assign pll_pd        = pwr_down;
    assign osc_pd        = pwr_down;

    // R2: a stopped CPU group implies stopped buffered 66 MHz outputs
    p_chain_cpu_r2: assert property (@(posedge clk) disable iff (rst)
        !en[G_CPU] |-> !en[G_B66]);

    // R2: stopped buffered outputs imply a stopped PCI group
    p_chain_buf_r2: assert property (@(posedge clk) disable iff (rst)
        !en[G_B66] |-> !en[G_PCI]);

endmodule

// File: tb/tb_clk_suspend_seq.sv
module tb_clk_suspend_seq;

    localparam int EXIT_TICKS = 1432;
    localparam int TICK_DIV   = 8;
    localparam int LOCK_DLY   = 50;
    localparam int NV         = 6;

    // {pd_n, settle cycles[15:0], expected enables[6:0], expected power-down}
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 16'd16,    7'h7F, 1'b0},
        {1'b0, 16'd200,   7'h00, 1'b1},
        {1'b1, 16'd200,   7'h07, 1'b0},
        {1'b1, 16'd12000, 7'h7F, 1'b0},
        {1'b0, 16'd200,   7'h00, 1'b1},
        {1'b1, 16'd12200, 7'h7F, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pd_n = 1'b1;
    logic       pll_lock = 1'b0;
    logic       ref_tick = 1'b0;
    logic [6:0] grp_clk = '0;
    logic [6:0] grp_en;
    logic       cpu_true_hold, cpu_comp_oe, pll_pd, osc_pd;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 0;
    int fall_cyc [7];
    int rise_cyc [7];
    int lock_cyc = 0;
    int pdrise_cyc = 0;
    int pdfall_cyc = 0;

    clk_suspend_seq #(.EXIT_TICKS(EXIT_TICKS)) dut (
        .clk(clk), .rst(rst), .pd_n(pd_n), .pll_lock(pll_lock),
        .ref_tick(ref_tick), .grp_clk(grp_clk), .grp_en(grp_en),
        .cpu_true_hold(cpu_true_hold), .cpu_comp_oe(cpu_comp_oe),
        .pll_pd(pll_pd), .osc_pd(osc_pd)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_pd(input logic v);
        @(posedge clk);
        #2 pd_n = v;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check_outputs(input logic [6:0] een, input logic epd, input string tag);
        check(grp_en == een, tag, int'(grp_en), int'(een));
        check(pll_pd == epd && osc_pd == epd, tag, int'({pll_pd, osc_pd}), int'({epd, epd}));
        // R4: CPU leg drive follows the CPU enable
        check(cpu_true_hold == !een[0] && cpu_comp_oe == een[0], "R4",
              int'({cpu_true_hold, cpu_comp_oe}), int'({!een[0], een[0]}));
    endtask

    // clock, tick and lock models, driven 2 ns after each rising edge
    initial begin
        int ph;
        int half [7];
        int lcnt;
        half = '{1, 2, 2, 2, 4, 3, 5};
        ph = 0;
        lcnt = 0;
        forever begin
            @(posedge clk);
            #2;
            ph++;
            for (int g = 0; g < 7; g++) begin
                if (ph % half[g] == 0) grp_clk[g] = ~grp_clk[g];
            end
            ref_tick = (ph % TICK_DIV == 0);
            if (pll_pd) begin
                lcnt = 0;
                pll_lock = 1'b0;
            end else if (lcnt < LOCK_DLY) begin
                lcnt++;
            end else begin
                pll_lock = 1'b1;
            end
        end
    end

    // per-cycle monitor: edge alignment (R3) and change timestamps
    initial begin
        logic [6:0] seen1, seen2, prev_en;
        logic prev_lock, prev_pd;
        seen1 = '0;
        seen2 = '0;
        prev_en = 7'h7F;
        prev_lock = 1'b0;
        prev_pd = 1'b0;
        for (int g = 0; g < 7; g++) begin
            fall_cyc[g] = 0;
            rise_cyc[g] = 0;
        end
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst) begin
                for (int g = 0; g < 7; g++) begin
                    if (grp_en[g] != prev_en[g]) begin
                        if (g == 0) check(!seen2[g] && seen1[g], "R3", g, 0);
                        else        check(seen2[g] && !seen1[g], "R3", g, g);
                        if (grp_en[g]) rise_cyc[g] = cyc;
                        else           fall_cyc[g] = cyc;
                    end
                end
                if (pll_lock && !prev_lock) lock_cyc = cyc;
                if (pll_pd && !prev_pd) pdrise_cyc = cyc;
                if (!pll_pd && prev_pd) pdfall_cyc = cyc;
            end
            prev_en = grp_en;
            prev_lock = pll_lock;
            prev_pd = pll_pd;
            seen2 = seen1;
            seen1 = grp_clk;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int snap_b66, t1, tmax, d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_outputs(7'h7F, 1'b0, "R9 in reset");
        @(posedge clk);
        #2 rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            set_pd(VEC[i][24]);
            if (i == 5) t1 = cyc;
            settle(int'(VEC[i][23:8]));
            check_outputs(VEC[i][7:1], VEC[i][0], "R9/R2/R7 vector");
            if (i == 1 || i == 4) begin
                // R2: stop order
                check(fall_cyc[4] < fall_cyc[3] && fall_cyc[4] < fall_cyc[2], "R2",
                      fall_cyc[4], fall_cyc[3]);
                check(fall_cyc[3] < fall_cyc[0] && fall_cyc[2] < fall_cyc[1], "R2",
                      fall_cyc[3], fall_cyc[0]);
                check(fall_cyc[0] < fall_cyc[5] && fall_cyc[1] < fall_cyc[5], "R2",
                      fall_cyc[0], fall_cyc[5]);
                check(fall_cyc[5] < fall_cyc[6] && fall_cyc[6] < pdrise_cyc, "R2",
                      fall_cyc[6], pdrise_cyc);
            end
            if (i == 3) begin
                // R5: power back first, no release before lock
                check(pdfall_cyc < lock_cyc && lock_cyc < rise_cyc[0], "R5",
                      rise_cyc[0], lock_cyc);
                check(lock_cyc < rise_cyc[1] && lock_cyc < rise_cyc[2], "R5",
                      rise_cyc[2], lock_cyc);
                // R6: early three released before the rest, close together
                tmax = rise_cyc[0];
                if (rise_cyc[1] > tmax) tmax = rise_cyc[1];
                if (rise_cyc[2] > tmax) tmax = rise_cyc[2];
                check(tmax < rise_cyc[3] && tmax - rise_cyc[2] <= 12 && tmax - rise_cyc[0] <= 12,
                      "R6", tmax, rise_cyc[3]);
                // R7: delay window, then release order
                d = rise_cyc[3] - rise_cyc[2];
                check(d >= EXIT_TICKS * TICK_DIV - 16 && d <= EXIT_TICKS * TICK_DIV + 32, "R7",
                      d, EXIT_TICKS * TICK_DIV);
                check(d * 8 > 30000 && d * 8 < 400000, "R7", d * 8, 100000);
                check(rise_cyc[3] < rise_cyc[4] && rise_cyc[4] < rise_cyc[5] &&
                      rise_cyc[4] < rise_cyc[6], "R7", rise_cyc[4], rise_cyc[5]);
            end
        end
        // R10: time to fully running after request withdrawn
        tmax = 0;
        for (int g = 0; g < 7; g++) if (rise_cyc[g] > tmax) tmax = rise_cyc[g];
        check((tmax - t1) * 8 < 3000000, "R10", (tmax - t1) * 8, 3000000);

        // R1: one-cycle low pulse in run is ignored
        set_pd(1'b0);
        set_pd(1'b1);
        settle(40);
        check_outputs(7'h7F, 1'b0, "R1 low glitch");

        // R1: one-cycle high pulse in power-down is ignored
        set_pd(1'b0);
        settle(200);
        check_outputs(7'h00, 1'b1, "R1 enter");
        set_pd(1'b1);
        set_pd(1'b0);
        settle(100);
        check_outputs(7'h00, 1'b1, "R1 high glitch");

        // R8: abort during the exit delay
        set_pd(1'b1);
        settle(2000);
        check_outputs(7'h07, 1'b0, "R8 mid delay");
        snap_b66 = rise_cyc[3];
        set_pd(1'b0);
        settle(200);
        check_outputs(7'h00, 1'b1, "R8 aborted");
        check(rise_cyc[3] == snap_b66, "R8", rise_cyc[3], snap_b66);
        check(fall_cyc[2] < fall_cyc[0] && fall_cyc[0] < pdrise_cyc, "R8",
              fall_cyc[0], fall_cyc[2]);

        // recovery after abort
        set_pd(1'b1);
        t1 = cyc;
        settle(12300);
        check_outputs(7'h7F, 1'b0, "R10 recover");
        tmax = 0;
        for (int g = 0; g < 7; g++) if (rise_cyc[g] > tmax) tmax = rise_cyc[g];
        check((tmax - t1) * 8 < 3000000, "R10", (tmax - t1) * 8, 3000000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule